// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

The engine draws into a frame memory of 16-bit pixels. Software feeds it a stream of 32-bit command words on a valid/ready port. The top byte of each word is an opcode and the lower bits are its argument. Parameter words set the destination and source addresses, the rectangle size and the fill colour. A go word then starts one of two operations. A solid fill writes the loaded colour to every pixel of the destination rectangle. A copy moves the source rectangle to the destination rectangle one pixel at a time.

Memory is reached through a word-addressed request port with a ready grant. Read data comes back on a separate valid strobe. The line pitch, in pixels, is a configuration input. While an operation runs, the engine reports busy and holds off new commands. When it finishes, it sets a sticky completion flag, which software clears by writing a one.

The controller has five states:
- ST_IDLE accepts commands.
- ST_FILL_WR issues fill writes.
- ST_CP_RD issues a copy read.
- ST_CP_WAIT waits for the returned pixel.
- ST_CP_WR writes that pixel.

The state transitions are:
- ST_IDLE goes to ST_FILL_WR on a fill go and to ST_CP_RD on a copy go.
- ST_FILL_WR stays in place until the last write is granted, then returns to ST_IDLE.
- ST_CP_RD goes to ST_CP_WAIT on a grant.
- ST_CP_WAIT goes to ST_CP_WR when read data is valid.
- ST_CP_WR goes back to ST_CP_RD on a grant, or to ST_IDLE on the grant of the last pixel.

Top module: `rect_blitter`

## Requirements
- R1: The parameter opcodes take their argument from the bits below the opcode:
  - 0x0C loads the destination byte address and 0x0D loads the source byte address. Both are taken from bits ADDR_W-1:1, so bit 0 is always zero.
  - 0x0E loads the width field and 0x0F loads the height field. Each is a 10-bit field in bits 9:0 holding the pixel count minus one.
  - 0x0B loads the colour from bits 15:0.
- R2: Opcode 0x23 writes the colour to every pixel of the destination rectangle. The pixel in row r and column c is at byte address base + (r*pitch + c)*2, which is word address base/2 + r*pitch + c.
- R3: Opcode 0x21 copies the source rectangle to the destination rectangle. Each pixel is read first and then written. Pixels are visited row by row from the top, and left to right within a row, so overlapping copies follow this order.
- R4: busy is high from the cycle after a go word is accepted until the last write is granted. cmd_ready is low the whole time busy is high.
- R5: done_flag goes high in the cycle after the last write is granted. A pulse on done_clr clears it.
- R6: If a completion and a done_clr pulse fall in the same cycle, done_flag ends up set.
- R7: Any opcode other than 0x0B, 0x0C, 0x0D, 0x0E, 0x0F, 0x21 and 0x23 is accepted and ignored. It starts no memory access and changes no parameter.
- R8: Parameter values persist after an operation, so a go word alone repeats with the previous settings.
- R9: While a request waits for its grant, the request and its address, write enable and data stay stable. No request is made while the engine is idle.
- R10: After reset, busy and done_flag are low, cmd_ready is high and there is no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| pitch_pix | input | PITCH_W | line pitch in pixels |
| cmd_valid | input | 1 | command word offered |
| cmd_ready | output | 1 | command word accepted this cycle when valid |
| cmd_word | input | 32 | opcode in 31:24, argument below |
| mem_valid | output | 1 | memory request |
| mem_we | output | 1 | request is a write |
| mem_addr | output | ADDR_W-1 | pixel word address |
| mem_wdata | output | PIX_W | write pixel |
| mem_ready | input | 1 | request granted |
| mem_rvalid | input | 1 | read data valid |
| mem_rdata | input | PIX_W | read pixel |
| busy | output | 1 | operation in progress |
| done_flag | output | 1 | sticky completion flag |
| done_clr | input | 1 | write-one clear of done_flag |

## Verification
The completion flag has two writers that can act in the same cycle: the grant of the last pixel write sets it, and a done_clr pulse clears it. The bench sets up this collision with a single-pixel fill while the memory grants every request. It raises done_clr in exactly the cycle whose closing edge grants the write. It then requires done_flag to read one after the operation ends. A separate clear, given away from any completion, must still bring the flag to zero.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam logic [7:0] OP_COLOUR  = 8'h0B;
    localparam logic [7:0] OP_DST     = 8'h0C;
    localparam logic [7:0] OP_SRC     = 8'h0D;
    localparam logic [7:0] OP_WIDTH   = 8'h0E;
    localparam logic [7:0] OP_HEIGHT  = 8'h0F;
    localparam logic [7:0] OP_GO_COPY = 8'h21;
    localparam logic [7:0] OP_GO_FILL = 8'h23;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_WR,
        ST_CP_RD,
        ST_CP_WAIT,
        ST_CP_WR
    } blit_state_t;

endpackage

// File: rtl/blit_param_regs.sv
module blit_param_regs
    import blit_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DIM_W  = 10,
    parameter int PIX_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [31:0]       word,
    output logic [ADDR_W-2:0] dst_wa,
    output logic [ADDR_W-2:0] src_wa,
    output logic [DIM_W-1:0]  width_m1,
    output logic [DIM_W-1:0]  height_m1,
    output logic [PIX_W-1:0]  colour
);

    logic [7:0] opcode;
    assign opcode = word[31:24];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_wa    <= '0;
            src_wa    <= '0;
            width_m1  <= '0;
            height_m1 <= '0;
            colour    <= '0;
        end else if (load) begin
            case (opcode)
                OP_DST:    dst_wa    <= word[ADDR_W-1:1];
                OP_SRC:    src_wa    <= word[ADDR_W-1:1];
                OP_WIDTH:  width_m1  <= word[DIM_W-1:0];
                OP_HEIGHT: height_m1 <= word[DIM_W-1:0];
                OP_COLOUR: colour    <= word[PIX_W-1:0];
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
    parameter int ADDR_W  = 24,
    parameter int DIM_W   = 10,
    parameter int PITCH_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               step,
    input  logic [ADDR_W-2:0]  dst_base,
    input  logic [ADDR_W-2:0]  src_base,
    input  logic [DIM_W-1:0]   width_m1,
    input  logic [DIM_W-1:0]   height_m1,
    input  logic [PITCH_W-1:0] pitch_pix,
    output logic [ADDR_W-2:0]  dst_addr,
    output logic [ADDR_W-2:0]  src_addr,
    output logic               last
);

    localparam int AW = ADDR_W - 1;

    logic [DIM_W-1:0] col, row;
    logic [AW-1:0]    dst_row, src_row;
    logic             row_end;

    assign row_end  = (col == width_m1);
    assign last     = row_end && (row == height_m1);
    assign dst_addr = dst_row + AW'(col);
    assign src_addr = src_row + AW'(col);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col     <= '0;
            row     <= '0;
            dst_row <= '0;
            src_row <= '0;
        end else if (start) begin
            col     <= '0;
            row     <= '0;
            dst_row <= dst_base;
            src_row <= src_base;
        end else if (step) begin
            if (row_end) begin
                col     <= '0;
                row     <= row + 1'b1;
                dst_row <= dst_row + AW'(pitch_pix);
                src_row <= src_row + AW'(pitch_pix);
            end else begin
                col <= col + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rect_blitter.sv
module rect_blitter
    import blit_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DIM_W   = 10,
    parameter int PIX_W   = 16,
    parameter int PITCH_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PITCH_W-1:0] pitch_pix,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [31:0]        cmd_word,
    output logic               mem_valid,
    output logic               mem_we,
    output logic [ADDR_W-2:0]  mem_addr,
    output logic [PIX_W-1:0]   mem_wdata,
    input  logic               mem_ready,
    input  logic               mem_rvalid,
    input  logic [PIX_W-1:0]   mem_rdata,
    output logic               busy,
    output logic               done_flag,
    input  logic               done_clr
);

    blit_state_t       state, state_nxt;
    logic              accept, go_fill, go_copy, step, last, finish;
    logic [ADDR_W-2:0] dst_wa, src_wa, dst_addr, src_addr;
    logic [DIM_W-1:0]  width_m1, height_m1;
    logic [PIX_W-1:0]  colour, pix_q;

    assign accept  = cmd_valid && cmd_ready;
    assign go_fill = accept && (cmd_word[31:24] == OP_GO_FILL);
    assign go_copy = accept && (cmd_word[31:24] == OP_GO_COPY);

    blit_param_regs #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PIX_W(PIX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .load(accept), .word(cmd_word),
        .dst_wa(dst_wa), .src_wa(src_wa), .width_m1(width_m1),
        .height_m1(height_m1), .colour(colour)
    );

    blit_walker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PITCH_W(PITCH_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(go_fill || go_copy), .step(step),
        .dst_base(dst_wa), .src_base(src_wa), .width_m1(width_m1),
        .height_m1(height_m1), .pitch_pix(pitch_pix),
        .dst_addr(dst_addr), .src_addr(src_addr), .last(last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (go_fill)      state_nxt = ST_FILL_WR;
                else if (go_copy) state_nxt = ST_CP_RD;
            end
            ST_FILL_WR: if (mem_ready && last) state_nxt = ST_IDLE;
            ST_CP_RD:   if (mem_ready)  state_nxt = ST_CP_WAIT;
            ST_CP_WAIT: if (mem_rvalid) state_nxt = ST_CP_WR;
            ST_CP_WR:   if (mem_ready)  state_nxt = last ? ST_IDLE : ST_CP_RD;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_ready = (state == ST_IDLE);
        busy      = (state != ST_IDLE);
        mem_valid = (state == ST_FILL_WR) || (state == ST_CP_RD) || (state == ST_CP_WR);
        mem_we    = (state == ST_FILL_WR) || (state == ST_CP_WR);
        mem_addr  = (state == ST_CP_RD) ? src_addr : dst_addr;
        mem_wdata = (state == ST_FILL_WR) ? colour : pix_q;
        step      = mem_ready && mem_we;
        finish    = step && last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q     <= '0;
            done_flag <= 1'b0;
        end else begin
            if (state == ST_CP_WAIT && mem_rvalid) pix_q <= mem_rdata;
            if (finish)        done_flag <= 1'b1;
            else if (done_clr) done_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rect_blitter_checker.sv
module rect_blitter_checker #(
    parameter int ADDR_W = 24,
    parameter int PIX_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [31:0]       cmd_word,
    input logic              mem_valid,
    input logic              mem_we,
    input logic [ADDR_W-2:0] mem_addr,
    input logic [PIX_W-1:0]  mem_wdata,
    input logic              mem_ready,
    input logic              busy,
    input logic              done_flag,
    input logic              done_clr
);

    logic is_go, is_known;
    assign is_go    = (cmd_word[31:24] == 8'h21) || (cmd_word[31:24] == 8'h23);
    assign is_known = is_go || (cmd_word[31:24] >= 8'h0B && cmd_word[31:24] <= 8'h0F);

    AST_GO_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && is_go) |=> busy); // R4

    AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_ready); // R4

    AST_DONE_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> ($past(busy) && !busy)); // R5

    AST_DONE_CLEARED_BY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_flag) |-> $past(done_clr)); // R5

    AST_END_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag); // R6

    AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !is_known) |=> (!busy && !mem_valid)); // R7

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_we) && $stable(mem_wdata))); // R9

    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_valid); // R9

endmodule

bind rect_blitter rect_blitter_checker #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .busy(busy), .done_flag(done_flag), .done_clr(done_clr)
);

// File: tb/rect_blitter_tb.sv
module rect_blitter_tb;

    localparam int ADDR_W  = 12;
    localparam int PIX_W   = 16;
    localparam int PITCH_W = 12;
    localparam int WORDS   = 2048;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [PITCH_W-1:0] pitch_pix = 12'd32;
    logic               cmd_valid = 1'b0;
    logic               cmd_ready;
    logic [31:0]        cmd_word = '0;
    logic               mem_valid, mem_we, mem_ready;
    logic [ADDR_W-2:0]  mem_addr;
    logic [PIX_W-1:0]   mem_wdata;
    logic               mem_rvalid;
    logic [PIX_W-1:0]   mem_rdata;
    logic               busy, done_flag;
    logic               done_clr = 1'b0;
    logic               stall_mode = 1'b1;
    logic [7:0]         lfsr;

    logic [15:0] mem [0:WORDS-1];
    logic [15:0] exp_mem [0:WORDS-1];
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    rect_blitter #(.ADDR_W(ADDR_W), .DIM_W(10), .PIX_W(PIX_W), .PITCH_W(PITCH_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .pitch_pix(pitch_pix),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .busy(busy), .done_flag(done_flag), .done_clr(done_clr)
    );

    assign mem_ready = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= 16'(i * 37) ^ 16'h5A5A;
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            lfsr       <= 8'hA5;
        end else begin
            lfsr       <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mem_rvalid <= 1'b0;
            if (mem_valid && mem_ready) begin
                if (mem_we) mem[mem_addr] <= mem_wdata;
                else begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mem[mem_addr];
                end
            end
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic compare_mem(input string req);
        int mism = 0;
        int first = -1;
        for (int i = 0; i < WORDS; i++)
            if (mem[i] !== exp_mem[i]) begin
                mism++;
                if (first < 0) first = i;
            end
        total++;
        if (mism != 0) begin
            bad++;
            $display("FAIL %s word %0h actual=%0h expected=%0h (%0d mismatches)",
                     req, first, mem[first], exp_mem[first], mism);
        end
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 4000) begin
            @(negedge clk);
            n++;
        end
        check(!busy, "R4 finish", busy, 0);
    endtask

    task automatic clear_done();
        @(negedge clk);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        check(done_flag == 1'b0, "R5 clear", done_flag, 0);
    endtask

    task automatic exp_fill(input int dst, input int w, input int h, input int col);
        for (int r = 0; r <= h; r++)
            for (int c = 0; c <= w; c++)
                exp_mem[(dst / 2 + r * int'(pitch_pix) + c) % WORDS] = 16'(col);
    endtask

    task automatic exp_copy(input int src, input int dst, input int w, input int h);
        for (int r = 0; r <= h; r++)
            for (int c = 0; c <= w; c++)
                exp_mem[(dst / 2 + r * int'(pitch_pix) + c) % WORDS] =
                    exp_mem[(src / 2 + r * int'(pitch_pix) + c) % WORDS];
    endtask

    task automatic finish_op(input string req);
        check(busy == 1'b1 && cmd_ready == 1'b0, "R4 busy", busy, 1);
        wait_idle();
        check(done_flag == 1'b1, "R5 set", done_flag, 1);
        compare_mem(req);
        clear_done();
    endtask

    task automatic run_fill(input int dst, input int w, input int h, input int col);
        send({8'h0C, 24'(dst)});
        send({8'h0E, 24'(w)});
        send({8'h0F, 24'(h)});
        send({8'h0B, 24'(col)});
        send(32'h2300_0000);
        exp_fill(dst, w, h, col);
        finish_op("R2 fill");
    endtask

    task automatic run_copy(input int src, input int dst, input int w, input int h);
        send({8'h0D, 24'(src)});
        send({8'h0C, 24'(dst)});
        send({8'h0E, 24'(w)});
        send({8'h0F, 24'(h)});
        send(32'h2100_0000);
        exp_copy(src, dst, w, h);
        finish_op("R3 copy");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R4 actual=hung expected=idle");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) exp_mem[i] = 16'(i * 37) ^ 16'h5A5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(busy == 1'b0 && done_flag == 1'b0, "R10 status", {busy, done_flag}, 0);
        check(cmd_ready == 1'b1 && mem_valid == 1'b0, "R10 ports", {cmd_ready, mem_valid}, 2);

        // R2 fill sweep over sizes and positions with stalls
        for (int w = 0; w < 4; w++)
            for (int h = 0; h < 3; h++)
                run_fill(32'h100 + w * 2 + h * 64, w, h, 32'hA000 + w * 16 + h);

        // R3 copy sweep, disjoint areas
        for (int w = 0; w < 4; w++)
            for (int h = 0; h < 3; h++)
                run_copy(32'h600 + h * 2, 32'h200 + w * 4 + h * 64, w, h);

        // R3 overlapping copy: destination one pixel right of source, forward order smears
        run_copy(32'h300, 32'h302, 4, 1);
        // R3 overlapping copy: destination one row below source
        run_copy(32'h380, 32'h380 + 64, 2, 2);

        // R1 argument masking: odd address bit, high width/height bits, upper colour bits
        send(32'h0C00_0501);
        send(32'h0E00_FC02);
        send(32'h0F00_FC01);
        send(32'h0BAB_1234);
        send(32'h2300_0000);
        exp_fill(32'h500, 2, 1, 16'h1234);
        finish_op("R1 masking");

        // R8 reuse: change only destination, then go alone
        send(32'h0C00_0540);
        send(32'h2300_0000);
        exp_fill(32'h540, 2, 1, 16'h1234);
        finish_op("R8 reuse fill");

        // R7 unknown opcodes accepted and ignored
        send(32'h2400_0005);
        check(busy == 1'b0 && mem_valid == 1'b0, "R7 line op", busy, 0);
        send(32'h0A00_FFFF);
        check(busy == 1'b0 && mem_valid == 1'b0, "R7 other op", busy, 0);
        send(32'h2200_0000);
        check(busy == 1'b0 && done_flag == 1'b0, "R7 scale op", busy, 0);
        send(32'h1000_0007);
        repeat (3) @(negedge clk);
        compare_mem("R7 no write");
        send(32'h2300_0000);
        exp_fill(32'h540, 2, 1, 16'h1234);
        finish_op("R7 params kept");

        // R2 different pitch
        pitch_pix = 12'd20;
        run_fill(32'h700, 3, 3, 16'h0F0F);
        run_copy(32'h700, 32'h720, 3, 3);
        pitch_pix = 12'd32;

        // R6 completion and clear in the same cycle
        stall_mode = 1'b0;
        send(32'h0C00_07F0);
        send(32'h0E00_0000);
        send(32'h0F00_0000);
        send(32'h0B00_BEEF);
        send(32'h2300_0000);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        check(busy == 1'b0, "R6 ended", busy, 0);
        check(done_flag == 1'b1, "R6 set wins", done_flag, 1);
        exp_fill(32'h7F0, 0, 0, 16'hBEEF);
        compare_mem("R6 write");
        clear_done();

        // R8 copy reuse with no stalls
        send(32'h0D00_0100);
        send(32'h0C00_0780);
        send(32'h0E00_0002);
        send(32'h0F00_0001);
        send(32'h2100_0000);
        exp_copy(32'h100, 32'h780, 2, 1);
        finish_op("R8 copy");
        send(32'h0C00_07A0);
        send(32'h2100_0000);
        exp_copy(32'h100, 32'h7A0, 2, 1);
        finish_op("R8 copy reuse");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule